// File: doc/BRIEF.md
# Windowed Memory Address Router

This block sits between a 32-bit core's byte-addressed load, store and instruction-fetch requests and four targets: main RAM, a shared-memory window, a local register-file window and an I/O mailbox. It compares each request address against fixed window boundaries, rebases the address for the chosen target, and holds the request until that target completes. Only then does it give the core a one-cycle ready pulse carrying the read data.

Main RAM is stored little-endian, so byte and halfword addresses are lane-swizzled by XOR before they reach it. The other windows see unswizzled addresses. I/O goes through a mailbox. The router posts the port, the data and a command code, and waits until the external handler signals that the command register has gone back to zero. One I/O address returns a free-running cycle counter directly, with no mailbox traffic.

Top module: `addr_window_router`

## Requirements
- R1: While reset is asserted and just after it, req_ready, ram_req, shm_req and reg_req are low and io_cmd is 0.
- R2: An address below 0x10000000 selects main RAM. A word access (req_size 00) passes the address unchanged, and ram_req holds with a stable address until ram_ack.
- R3: For main RAM, a byte access (req_size 10) and an instruction fetch (req_size 11) present the address XOR 3. A halfword access (req_size 01) presents the address XOR 2.
- R4: An address from 0x10000000 up to 0x18000000 selects the shared window. shm_addr is the address minus 0x10000000, with no lane swizzle.
- R5: An address from 0x18000000 up to 0x1F000000 selects the register window. reg_idx is the address shifted right by 2, truncated to REG_IDX_W bits. reg_req is a single-cycle strobe, and reg_rdata is taken on the next clock edge.
- R6: An I/O write (address at or above 0x1F000000) sets io_port to the full address, io_wdata to the write data and io_cmd to 1. io_cmd holds until io_done, which clears it to 0 and completes the access.
- R7: An I/O read posts io_cmd 2 with io_port set to the address, and returns io_rdata as captured when io_done arrives.
- R8: A read at 0x80000100 returns a 32-bit counter that increments every clock, without using the mailbox. The difference between two such reads equals the number of cycles between their responses. A write to that address goes to the mailbox as a normal I/O write.
- R9: At most one of ram_req, shm_req, reg_req or a nonzero io_cmd is active at a time. req_ready is a single-cycle pulse, and it follows completion of the selected target.
- R10: A completed write returns req_rdata equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present, held until req_ready |
| req_write | input | 1 | 1 = store, 0 = load or fetch |
| req_size | input | 2 | 00 word, 01 halfword, 10 byte, 11 instruction fetch |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Load data, valid with req_ready |
| ram_req | output | 1 | Main RAM request, held until ram_ack |
| ram_we | output | 1 | Main RAM write enable |
| ram_size | output | 2 | Access size, same encoding as req_size |
| ram_addr | output | 32 | Lane-swizzled RAM byte address |
| ram_wdata | output | 32 | RAM write data |
| ram_ack | input | 1 | RAM completion pulse |
| ram_rdata | input | 32 | RAM read data, valid with ram_ack |
| shm_req | output | 1 | Shared window request, held until shm_ack |
| shm_we | output | 1 | Shared window write enable |
| shm_addr | output | 32 | Offset into the shared window |
| shm_wdata | output | 32 | Shared window write data |
| shm_ack | input | 1 | Shared window completion pulse |
| shm_rdata | input | 32 | Shared window read data |
| reg_req | output | 1 | Register window strobe, one cycle |
| reg_we | output | 1 | Register window write enable |
| reg_idx | output | REG_IDX_W | Register word index |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, sampled the edge after reg_req |
| io_cmd | output | 2 | Mailbox command: 0 idle, 1 output, 2 input |
| io_port | output | 32 | Mailbox port address |
| io_wdata | output | 32 | Mailbox output data |
| io_done | input | 1 | Handler completion pulse, clears io_cmd |
| io_rdata | input | 32 | Mailbox input data, valid with io_done |

## Verification
A wrong window comparison or rebase shows up as a strobe on the wrong target, or as an offset address, on the first negative edge after the request is accepted. A broken lane swizzle shows up the same way on ram_addr. A state machine that loses its place shows as two active targets, as a ready pulse longer than one cycle, or as a hang the watchdog catches within one access. A counter fault shows as two timer reads whose difference does not match the spacing of their responses.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CMD_W  = 2;

  typedef enum logic [1:0] {
    SZ_WORD  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_BYTE  = 2'b10,
    SZ_FETCH = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_RAM = 2'd0,
    TGT_SHM = 2'd1,
    TGT_REG = 2'd2,
    TGT_IO  = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RAM  = 3'd1,
    ST_SHM  = 3'd2,
    ST_REG  = 3'd3,
    ST_IO   = 3'd4,
    ST_RESP = 3'd5
  } rstate_e;

  localparam logic [CMD_W-1:0] CMD_IDLE = 2'd0;
  localparam logic [CMD_W-1:0] CMD_OUT  = 2'd1;
  localparam logic [CMD_W-1:0] CMD_IN   = 2'd2;
endpackage

// File: rtl/lane_swizzle.sv
module lane_swizzle
  import router_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr_in,
  input  acc_size_e     size,
  output logic [AW-1:0] addr_out
);
  localparam int LANE_BITS = 2;

  logic [LANE_BITS-1:0] flip;

  always_comb begin
    case (size)
      SZ_BYTE, SZ_FETCH: flip = 2'b11;
      SZ_HALF:           flip = 2'b10;
      default:           flip = 2'b00;
    endcase
    addr_out = {addr_in[AW-1:LANE_BITS], addr_in[LANE_BITS-1:0] ^ flip};
  end
endmodule

// File: rtl/window_decode.sv
module window_decode
  import router_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SHM_BASE   = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] REG_BASE   = 32'h1800_0000,
  parameter logic [ADDR_W-1:0] IO_BASE    = 32'h1F00_0000,
  parameter logic [ADDR_W-1:0] TIMER_ADDR = 32'h8000_0100,
  parameter int                REG_IDX_W  = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  acc_size_e            size,
  input  logic                 write,
  output tgt_e                 tgt,
  output logic [ADDR_W-1:0]    ram_addr,
  output logic [ADDR_W-1:0]    shm_addr,
  output logic [REG_IDX_W-1:0] reg_idx,
  output logic                 is_timer
);
  localparam int IDX_LO = 2;

  lane_swizzle #(.AW(ADDR_W)) u_swz (
    .addr_in (addr),
    .size    (size),
    .addr_out(ram_addr)
  );

  always_comb begin
    if (addr < SHM_BASE)      tgt = TGT_RAM;
    else if (addr < REG_BASE) tgt = TGT_SHM;
    else if (addr < IO_BASE)  tgt = TGT_REG;
    else                      tgt = TGT_IO;
  end

  assign shm_addr = addr - SHM_BASE;
  assign reg_idx  = addr[IDX_LO +: REG_IDX_W];
  assign is_timer = !write && (addr == TIMER_ADDR);
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] count
);
  logic [W-1:0] count_d;

  always_comb count_d = count + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count <= '0;
    else if (en) count <= count_d;
  end
endmodule

// File: rtl/io_mailbox.sv
module io_mailbox
  import router_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post,
  input  logic             post_write,
  input  logic [AW-1:0]    post_port,
  input  logic [DW-1:0]    post_data,
  input  logic             done,
  output logic [CMD_W-1:0] cmd,
  output logic [AW-1:0]    port,
  output logic [DW-1:0]    wdata,
  output logic             complete
);
  logic [CMD_W-1:0] cmd_d;
  logic             busy;

  assign busy     = (cmd != CMD_IDLE);
  assign complete = busy && done;

  always_comb begin
    cmd_d = cmd;
    if (post)          cmd_d = post_write ? CMD_OUT : CMD_IN;
    else if (complete) cmd_d = CMD_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd <= CMD_IDLE;
    else        cmd <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port  <= '0;
      wdata <= '0;
    end else if (post) begin
      port  <= post_port;
      wdata <= post_data;
    end
  end
endmodule

// File: rtl/addr_window_router.sv
module addr_window_router
  import router_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SHM_BASE   = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] REG_BASE   = 32'h1800_0000,
  parameter logic [ADDR_W-1:0] IO_BASE    = 32'h1F00_0000,
  parameter logic [ADDR_W-1:0] TIMER_ADDR = 32'h8000_0100,
  parameter int                REG_IDX_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 req_ready,
  output logic [DATA_W-1:0]    req_rdata,
  output logic                 ram_req,
  output logic                 ram_we,
  output logic [1:0]           ram_size,
  output logic [ADDR_W-1:0]    ram_addr,
  output logic [DATA_W-1:0]    ram_wdata,
  input  logic                 ram_ack,
  input  logic [DATA_W-1:0]    ram_rdata,
  output logic                 shm_req,
  output logic                 shm_we,
  output logic [ADDR_W-1:0]    shm_addr,
  output logic [DATA_W-1:0]    shm_wdata,
  input  logic                 shm_ack,
  input  logic [DATA_W-1:0]    shm_rdata,
  output logic                 reg_req,
  output logic                 reg_we,
  output logic [REG_IDX_W-1:0] reg_idx,
  output logic [DATA_W-1:0]    reg_wdata,
  input  logic [DATA_W-1:0]    reg_rdata,
  output logic [CMD_W-1:0]     io_cmd,
  output logic [ADDR_W-1:0]    io_port,
  output logic [DATA_W-1:0]    io_wdata,
  input  logic                 io_done,
  input  logic [DATA_W-1:0]    io_rdata
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted at once, released through a short synchronizer
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync[SYNC_STAGES-1];

  // free-running counter served at the timer address
  logic [DATA_W-1:0] cyc_cnt;

  cycle_counter #(.W(DATA_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_core_n),
    .en   (1'b1),
    .count(cyc_cnt)
  );

  // address decode of the incoming request
  acc_size_e            in_size;
  tgt_e                 dec_tgt;
  logic [ADDR_W-1:0]    dec_ram_addr;
  logic [ADDR_W-1:0]    dec_shm_addr;
  logic [REG_IDX_W-1:0] dec_reg_idx;
  logic                 dec_timer;

  assign in_size = acc_size_e'(req_size);

  window_decode #(
    .SHM_BASE  (SHM_BASE),
    .REG_BASE  (REG_BASE),
    .IO_BASE   (IO_BASE),
    .TIMER_ADDR(TIMER_ADDR),
    .REG_IDX_W (REG_IDX_W)
  ) u_dec (
    .addr    (req_addr),
    .size    (in_size),
    .write   (req_write),
    .tgt     (dec_tgt),
    .ram_addr(dec_ram_addr),
    .shm_addr(dec_shm_addr),
    .reg_idx (dec_reg_idx),
    .is_timer(dec_timer)
  );

  // transaction state
  rstate_e           state_q, state_d;
  logic              we_q, we_d;
  acc_size_e         size_q, size_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              ram_req_q, ram_req_d;
  logic              shm_req_q, shm_req_d;
  logic              reg_req_q, reg_req_d;
  logic              ready_q, ready_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              mb_post;
  logic              mb_complete;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && req_valid;

  io_mailbox #(.AW(ADDR_W), .DW(DATA_W)) u_mb (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .post      (mb_post),
    .post_write(req_write),
    .post_port (req_addr),
    .post_data (req_wdata),
    .done      (io_done),
    .cmd       (io_cmd),
    .port      (io_port),
    .wdata     (io_wdata),
    .complete  (mb_complete)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    we_d      = we_q;
    size_d    = size_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    ram_req_d = ram_req_q;
    shm_req_d = shm_req_q;
    reg_req_d = 1'b0;
    ready_d   = 1'b0;
    rdata_d   = rdata_q;
    mb_post   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          we_d    = req_write;
          size_d  = in_size;
          wdata_d = req_wdata;
          case (dec_tgt)
            TGT_RAM: begin
              addr_d    = dec_ram_addr;
              ram_req_d = 1'b1;
              state_d   = ST_RAM;
            end
            TGT_SHM: begin
              addr_d    = dec_shm_addr;
              shm_req_d = 1'b1;
              state_d   = ST_SHM;
            end
            TGT_REG: begin
              addr_d    = ADDR_W'(dec_reg_idx);
              reg_req_d = 1'b1;
              state_d   = ST_REG;
            end
            default: begin
              addr_d = req_addr;
              if (dec_timer) begin
                rdata_d = cyc_cnt;
                ready_d = 1'b1;
                state_d = ST_RESP;
              end else begin
                mb_post = 1'b1;
                state_d = ST_IO;
              end
            end
          endcase
        end
      end
      ST_RAM: begin
        if (ram_ack) begin
          ram_req_d = 1'b0;
          ready_d   = 1'b1;
          rdata_d   = we_q ? '0 : ram_rdata;
          state_d   = ST_RESP;
        end
      end
      ST_SHM: begin
        if (shm_ack) begin
          shm_req_d = 1'b0;
          ready_d   = 1'b1;
          rdata_d   = we_q ? '0 : shm_rdata;
          state_d   = ST_RESP;
        end
      end
      ST_REG: begin
        ready_d = 1'b1;
        rdata_d = we_q ? '0 : reg_rdata;
        state_d = ST_RESP;
      end
      ST_IO: begin
        if (mb_complete) begin
          ready_d = 1'b1;
          rdata_d = we_q ? '0 : io_rdata;
          state_d = ST_RESP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      size_q    <= SZ_WORD;
      addr_q    <= '0;
      wdata_q   <= '0;
      ram_req_q <= 1'b0;
      shm_req_q <= 1'b0;
      reg_req_q <= 1'b0;
      ready_q   <= 1'b0;
      rdata_q   <= '0;
    end else begin
      state_q   <= state_d;
      we_q      <= we_d;
      size_q    <= size_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      ram_req_q <= ram_req_d;
      shm_req_q <= shm_req_d;
      reg_req_q <= reg_req_d;
      ready_q   <= ready_d;
      rdata_q   <= rdata_d;
    end
  end

  // outputs
  assign req_ready = ready_q;
  assign req_rdata = rdata_q;
  assign ram_req   = ram_req_q;
  assign ram_we    = we_q;
  assign ram_size  = size_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;
  assign shm_req   = shm_req_q;
  assign shm_we    = we_q;
  assign shm_addr  = addr_q;
  assign shm_wdata = wdata_q;
  assign reg_req   = reg_req_q;
  assign reg_we    = we_q;
  assign reg_idx   = addr_q[REG_IDX_W-1:0];
  assign reg_wdata = wdata_q;
endmodule

// File: rtl/router_checker.sv
module router_checker
  import router_pkg::*;
#(
  parameter int REG_IDX_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 ram_req,
  input logic                 ram_ack,
  input logic [ADDR_W-1:0]    ram_addr,
  input logic [1:0]           ram_size,
  input logic                 shm_req,
  input logic                 shm_ack,
  input logic [ADDR_W-1:0]    shm_addr,
  input logic                 reg_req,
  input logic [REG_IDX_W-1:0] reg_idx,
  input logic [CMD_W-1:0]     io_cmd,
  input logic [ADDR_W-1:0]    io_port,
  input logic                 io_done
);
  // R9: never more than one target engaged
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_req, shm_req, reg_req, io_cmd != CMD_IDLE}));

  // R9: completion is a single-cycle pulse
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R2: RAM request holds with a stable address until acknowledged
  a_r2_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req && !ram_ack) |=> (ram_req && $stable(ram_addr) && $stable(ram_size)));

  // R4: shared window request holds until acknowledged
  a_r4_shm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shm_req && !shm_ack) |=> (shm_req && $stable(shm_addr)));

  // R5: register strobe lasts one cycle and is answered at once
  a_r5_reg_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> (!reg_req && req_ready));

  // R6: a posted command and port stay put until the handler finishes
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_cmd != CMD_IDLE) && !io_done) |=> ($stable(io_cmd) && $stable(io_port)));

  // R6: handler completion clears the command
  a_r6_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_cmd != CMD_IDLE) && io_done) |=> (io_cmd == CMD_IDLE));

  // R7: only the output and input codes are ever posted
  a_r7_cmd_code: assert property (@(posedge clk) disable iff (!rst_n)
    io_cmd != 2'd3);
endmodule

bind addr_window_router router_checker #(.REG_IDX_W(REG_IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .req_ready(req_ready),
  .ram_req  (ram_req),
  .ram_ack  (ram_ack),
  .ram_addr (ram_addr),
  .ram_size (ram_size),
  .shm_req  (shm_req),
  .shm_ack  (shm_ack),
  .shm_addr (shm_addr),
  .reg_req  (reg_req),
  .reg_idx  (reg_idx),
  .io_cmd   (io_cmd),
  .io_port  (io_port),
  .io_done  (io_done)
);

// File: tb/addr_window_router_test.sv
module addr_window_router_test;
  localparam int REG_IDX_W = 8;
  localparam logic [31:0] IDX_MASK = (32'd1 << REG_IDX_W) - 32'd1;
  localparam logic [31:0] TIMER = 32'h8000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                 req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]           req_size = 2'b00;
  logic [31:0]          req_addr = '0, req_wdata = '0;
  logic                 req_ready;
  logic [31:0]          req_rdata;
  logic                 ram_req, ram_we;
  logic [1:0]           ram_size;
  logic [31:0]          ram_addr, ram_wdata;
  logic                 ram_ack = 1'b0;
  logic [31:0]          ram_rdata = '0;
  logic                 shm_req, shm_we;
  logic [31:0]          shm_addr, shm_wdata;
  logic                 shm_ack = 1'b0;
  logic [31:0]          shm_rdata = '0;
  logic                 reg_req, reg_we;
  logic [REG_IDX_W-1:0] reg_idx;
  logic [31:0]          reg_wdata;
  logic [31:0]          reg_rdata = '0;
  logic [1:0]           io_cmd;
  logic [31:0]          io_port, io_wdata;
  logic                 io_done = 1'b0;
  logic [31:0]          io_rdata = '0;

  addr_window_router #(.REG_IDX_W(REG_IDX_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata),
    .ram_req(ram_req), .ram_we(ram_we), .ram_size(ram_size), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_ack(ram_ack), .ram_rdata(ram_rdata),
    .shm_req(shm_req), .shm_we(shm_we), .shm_addr(shm_addr), .shm_wdata(shm_wdata),
    .shm_ack(shm_ack), .shm_rdata(shm_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .io_cmd(io_cmd), .io_port(io_port), .io_wdata(io_wdata),
    .io_done(io_done), .io_rdata(io_rdata)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
  } tgt_exp_t;

  typedef struct packed {
    logic        chk;
    logic [31:0] data;
  } rsp_exp_t;

  tgt_exp_t tq[$];
  string    tq_tag[$];
  rsp_exp_t rq[$];
  string    rq_tag[$];

  int          n_chk = 0, n_bad = 0, cyc = 0, last_cyc = 0;
  logic [31:0] last_rdata = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tgt_seen(input logic [1:0] kind, input logic we, input logic [31:0] a, input logic [31:0] wd);
    tgt_exp_t got, e;
    string tg;
    got = '{kind: kind, we: we, addr: a, wdata: wd};
    if (tq.size() == 0) begin
      check(1'b0, "R9 unexpected target", 68'(got), 68'(0));
    end else begin
      e = tq.pop_front();
      tg = tq_tag.pop_front();
      check(got == e, tg, 68'(got), 68'(e));
    end
  endtask

  // RAM model (R2, R3)
  initial forever begin
    @(negedge clk);
    if (ram_req) begin
      tgt_seen(2'd0, ram_we, ram_addr, ram_wdata);
      repeat (2) @(negedge clk);
      ram_rdata = ram_addr ^ 32'h1111_1111;
      ram_ack = 1'b1;
      @(negedge clk);
      ram_ack = 1'b0;
    end
  end

  // shared window model (R4)
  initial forever begin
    @(negedge clk);
    if (shm_req) begin
      tgt_seen(2'd1, shm_we, shm_addr, shm_wdata);
      @(negedge clk);
      shm_rdata = shm_addr ^ 32'h2222_2222;
      shm_ack = 1'b1;
      @(negedge clk);
      shm_ack = 1'b0;
    end
  end

  // register window model (R5)
  initial forever begin
    @(negedge clk);
    if (reg_req) begin
      tgt_seen(2'd2, reg_we, 32'(reg_idx), reg_wdata);
      reg_rdata = 32'(reg_idx) ^ 32'h3333_3333;
    end
  end

  // mailbox handler (R6, R7)
  initial forever begin
    @(negedge clk);
    if (io_cmd != 2'd0) begin
      logic [1:0] c0;
      c0 = io_cmd;
      check(c0 == 2'd1 || c0 == 2'd2, "R7 command code", 68'(c0), 68'(1));
      tgt_seen(2'd3, c0 == 2'd1, io_port, io_wdata);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(io_cmd == c0 && !req_ready, "R6 command held while busy",
              68'({req_ready, io_cmd}), 68'(c0));
      end
      io_rdata = io_port ^ 32'h4444_4444;
      io_done = 1'b1;
      @(negedge clk);
      io_done = 1'b0;
      check(io_cmd == 2'd0, "R6 command cleared", 68'(io_cmd), 68'(0));
    end
  end

  // response monitor
  initial forever begin
    @(negedge clk);
    if (req_ready) begin
      last_rdata = req_rdata;
      last_cyc = cyc;
      if (rq.size() == 0) begin
        check(1'b0, "R9 unexpected ready", 68'(req_rdata), 68'(0));
      end else begin
        rsp_exp_t e;
        string tg;
        e = rq.pop_front();
        tg = rq_tag.pop_front();
        if (e.chk) check(req_rdata == e.data, tg, 68'(req_rdata), 68'(e.data));
      end
    end
  end

  function automatic logic [31:0] swz(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'b10 || sz == 2'b11) return a ^ 32'd3;
    if (sz == 2'b01) return a ^ 32'd2;
    return a;
  endfunction

  task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input string tag);
    tgt_exp_t e;
    logic [31:0] rd;
    bit timer;
    timer = 1'b0;
    if (a < 32'h1000_0000) begin
      e = '{kind: 2'd0, we: we, addr: swz(a, sz), wdata: wd};
      rd = e.addr ^ 32'h1111_1111;
    end else if (a < 32'h1800_0000) begin
      e = '{kind: 2'd1, we: we, addr: a - 32'h1000_0000, wdata: wd};
      rd = e.addr ^ 32'h2222_2222;
    end else if (a < 32'h1F00_0000) begin
      e = '{kind: 2'd2, we: we, addr: (a >> 2) & IDX_MASK, wdata: wd};
      rd = e.addr ^ 32'h3333_3333;
    end else begin
      e = '{kind: 2'd3, we: we, addr: a, wdata: wd};
      rd = a ^ 32'h4444_4444;
      timer = !we && (a == TIMER);
    end
    if (!timer) begin
      tq.push_back(e);
      tq_tag.push_back(tag);
    end
    rq.push_back('{chk: !timer, data: we ? 32'd0 : rd});
    rq_tag.push_back(we ? {tag, " / R10 write data"} : tag);
    @(negedge clk);
    req_write = we; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b0; req_wdata = '0;
    @(negedge clk);
    check(!req_ready, "R9 ready single pulse", 68'(req_ready), 68'(0));
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] t1;
    int c1;
    repeat (3) @(negedge clk);
    check({req_ready, ram_req, shm_req, reg_req, io_cmd} == 6'd0, "R1 in reset",
          68'({req_ready, ram_req, shm_req, reg_req, io_cmd}), 68'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({req_ready, ram_req, shm_req, reg_req, io_cmd} == 6'd0, "R1 after reset",
          68'({req_ready, ram_req, shm_req, reg_req, io_cmd}), 68'(0));

    access(1'b0, 2'b00, 32'h0000_1234, 32'd0, "R2 word read");
    access(1'b1, 2'b00, 32'h0FFF_FFFC, 32'hDEAD_BEEF, "R2 word write top of RAM");
    access(1'b0, 2'b10, 32'h0000_0100, 32'd0, "R3 byte xor 3");
    access(1'b0, 2'b10, 32'h0FFF_FFFF, 32'd0, "R3 byte at RAM limit");
    access(1'b0, 2'b01, 32'h0000_0202, 32'd0, "R3 half xor 2");
    access(1'b0, 2'b11, 32'h0000_0401, 32'd0, "R3 fetch xor 3");
    access(1'b1, 2'b01, 32'h0000_0010, 32'h0000_ABCD, "R3 half write");
    access(1'b0, 2'b00, 32'h1000_0000, 32'd0, "R4 shared base");
    access(1'b0, 2'b10, 32'h17FF_FFFF, 32'd0, "R4 shared top no swizzle");
    access(1'b1, 2'b00, 32'h1000_0ABC, 32'h1234_5678, "R4 shared write");
    access(1'b0, 2'b00, 32'h1800_0000, 32'd0, "R5 reg base");
    access(1'b0, 2'b00, 32'h1800_0010, 32'd0, "R5 reg index 4");
    access(1'b1, 2'b00, 32'h1EFF_FFFC, 32'hCAFE_F00D, "R5 reg top write");
    access(1'b1, 2'b00, 32'h1F00_0000, 32'h0000_0055, "R6 io write base");
    access(1'b1, 2'b10, 32'h9000_0004, 32'hA5A5_A5A5, "R6 io write high");
    access(1'b0, 2'b00, 32'h1F00_0040, 32'd0, "R7 io read");
    access(1'b0, 2'b00, 32'hFFFF_FFFC, 32'd0, "R7 io read top");

    access(1'b0, 2'b00, TIMER, 32'd0, "R8 timer read");
    t1 = last_rdata; c1 = last_cyc;
    repeat (7) @(negedge clk);
    access(1'b0, 2'b00, TIMER, 32'd0, "R8 timer read");
    check(last_rdata - t1 == 32'(last_cyc - c1), "R8 counter spacing",
          68'(last_rdata - t1), 68'(last_cyc - c1));
    check(last_cyc != c1, "R8 distinct responses", 68'(last_cyc), 68'(c1));
    access(1'b1, 2'b00, TIMER, 32'h0000_0077, "R8 timer write via mailbox");

    repeat (6) @(negedge clk);
    check(tq.size() == 0 && rq.size() == 0, "R9 all expectations consumed",
          68'(tq.size() + rq.size()), 68'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule